// File: doc/BRIEF.md
# Flash Timing Tick Divider

This block holds an 8-bit control byte and a prescaler. Together they turn the bus clock into a slow timing strobe, nominally 1 MHz, that paces the timed phases of flash program and erase operations. Software writes a 6-bit divide value and can then freeze it with a sticky lock bit. A read-only flag shows whether the byte has been written at all since reset.

A write is accepted only when the flash engine is idle, meaning the command-complete input is 1. There is one exception: while the flash reset sequence is running, writes are accepted even though command-complete is 0. An accepted write sets the loaded flag and may set the lock. It replaces the divide value unless the lock was already set before that write.

The tick generator is a down-counter. It reloads with the divide value and gives a one-cycle strobe every divide + 1 bus clocks. It produces no strobes until the loaded flag is 1, so a divide value that was never programmed cannot pace any timed event.

Top module: `ftd_top`

## Requirements
- R1: After reset the read data is 0x00, `loaded_o` is 0 and `tick_o` is 0.
- R2: Read data bit 7 and `loaded_o` read 0 until the first accepted write after reset, then read 1 until the next reset.
- R3: An accepted write with data bit 6 = 1 sets the lock bit, which reads back in bit 6. A write cannot clear it; only reset can.
- R4: While the lock bit reads 1, a write leaves the divide field in read bits 5:0 unchanged.
- R5: One accepted write that sets the lock bit, made while the lock is 0, also stores data bits 5:0 into the divide field.
- R6: A write with `cmd_done_i` = 0 and `rst_seq_i` = 0 changes no bit of the read data, including the loaded flag and the lock bit.
- R7: With `rst_seq_i` = 1, a write is accepted even though `cmd_done_i` = 0.
- R8: Once loaded, `tick_o` is high for exactly one cycle in every divide + 1 cycles. A divide value of 0 keeps it high every cycle.
- R9: `tick_o` stays 0 while the loaded flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Address-decoded byte write strobe |
| wr_data_i | input | 8 | Write data: bit 6 sets the lock, bits 5:0 carry the divide value |
| cmd_done_i | input | 1 | Command-complete flag; 0 while a flash command runs |
| rst_seq_i | input | 1 | High while the flash reset sequence runs |
| rd_data_o | output | 8 | Readback: {loaded, lock, divide[5:0]} |
| loaded_o | output | 1 | Register written since reset |
| tick_o | output | 1 | One-cycle timing strobe |

## Verification
A wrongly gated write shows up in the readback on the very next cycle. Examples are a write that lands while a command is busy, or a divide value overwritten after the lock was set. A lock or loaded flag that drops without a reset also shows in the readback one cycle later. A wrong reload value or an off-by-one in the counter appears as a strobe period other than divide + 1. This needs one full period after the first strobe to see. A strobe that fires before the first write shows on `tick_o` straight away.

// File: rtl/ftd_pkg.sv
package ftd_pkg;
    localparam int unsigned FTD_DIV_W = 6;
    localparam int unsigned FTD_REG_W = FTD_DIV_W + 2;
    localparam int unsigned FTD_LOCK_BIT = FTD_DIV_W;
    localparam int unsigned FTD_LOAD_BIT = FTD_DIV_W + 1;

    // A write lands when the engine is idle or the reset sequence runs.
    function automatic logic ftd_wr_ok(input logic wr_en, input logic cmd_done,
                                       input logic rst_seq);
        return wr_en && (cmd_done || rst_seq);
    endfunction
endpackage

// File: rtl/ftd_ctrl_reg.sv
module ftd_ctrl_reg #(
    parameter int unsigned DIV_W = ftd_pkg::FTD_DIV_W,
    localparam int unsigned REG_W = DIV_W + 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             cmd_done_i,
    input  logic             rst_seq_i,
    output logic             loaded_o,
    output logic             lock_o,
    output logic [DIV_W-1:0] div_o
);
    typedef struct packed {
        logic             loaded;
        logic             lock;
        logic [DIV_W-1:0] div;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  accept;

    always_comb begin
        st_d   = st_q;
        accept = ftd_pkg::ftd_wr_ok(wr_en_i, cmd_done_i, rst_seq_i);
        if (accept) begin
            st_d.loaded = 1'b1;
            st_d.lock   = st_q.lock | wr_data_i[DIV_W];
            if (!st_q.lock) begin
                st_d.div = wr_data_i[DIV_W-1:0];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign loaded_o = st_q.loaded;
    assign lock_o   = st_q.lock;
    assign div_o    = st_q.div;

    logic unused_hi;
    assign unused_hi = wr_data_i[REG_W-1];
endmodule

// File: rtl/ftd_tick_gen.sv
module ftd_tick_gen #(
    parameter int unsigned DIV_W = ftd_pkg::FTD_DIV_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } cnt_t;

    cnt_t cs_d, cs_q;
    logic at_zero;

    always_comb begin
        cs_d    = cs_q;
        at_zero = (cs_q.cnt == '0);
        if (!run_i) begin
            cs_d.cnt = '0;
        end else if (at_zero) begin
            cs_d.cnt = div_i;
        end else begin
            cs_d.cnt = cs_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cs_q <= '0;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign tick_o = run_i && at_zero;
endmodule

// File: rtl/ftd_top.sv
module ftd_top #(
    parameter int unsigned DIV_W = ftd_pkg::FTD_DIV_W,
    localparam int unsigned REG_W = DIV_W + 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             cmd_done_i,
    input  logic             rst_seq_i,
    output logic [REG_W-1:0] rd_data_o,
    output logic             loaded_o,
    output logic             tick_o
);
    logic             loaded;
    logic             lock;
    logic [DIV_W-1:0] div;

    ftd_ctrl_reg #(.DIV_W(DIV_W)) u_reg (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .cmd_done_i (cmd_done_i),
        .rst_seq_i  (rst_seq_i),
        .loaded_o   (loaded),
        .lock_o     (lock),
        .div_o      (div)
    );

    // The counter stays parked until the byte has been written once.
    ftd_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (loaded),
        .div_i  (div),
        .tick_o (tick_o)
    );

    assign rd_data_o = {loaded, lock, div};
    assign loaded_o  = loaded;
endmodule

// File: rtl/ftd_checker.sv
module ftd_checker #(
    parameter int unsigned DIV_W = ftd_pkg::FTD_DIV_W,
    localparam int unsigned REG_W = DIV_W + 2
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             wr_en_i,
    input logic             cmd_done_i,
    input logic             rst_seq_i,
    input logic [REG_W-1:0] rd_data_o,
    input logic             loaded_o,
    input logic             tick_o
);
    AST_LOADED_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        loaded_o |=> loaded_o); // R2
    AST_LOADED_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        loaded_o == rd_data_o[REG_W-1]); // R2
    AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_data_o[DIV_W] |=> rd_data_o[DIV_W]); // R3
    AST_DIV_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_data_o[DIV_W] |=> $stable(rd_data_o[DIV_W-1:0])); // R4
    AST_BUSY_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !cmd_done_i && !rst_seq_i) |=> $stable(rd_data_o)); // R6
    AST_SEQ_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && rst_seq_i) |=> loaded_o); // R7
    AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o && rd_data_o[DIV_W-1:0] != '0) |=> !tick_o); // R8
    AST_NO_TICK_UNLOADED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !loaded_o |-> !tick_o); // R9
endmodule

bind ftd_top ftd_checker #(.DIV_W(DIV_W)) u_ftd_checker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .cmd_done_i (cmd_done_i),
    .rst_seq_i  (rst_seq_i),
    .rd_data_o  (rd_data_o),
    .loaded_o   (loaded_o),
    .tick_o     (tick_o)
);

// File: tb/ftd_top_tb_top.sv
module ftd_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       cmd_done = 1'b1;
    logic       rst_seq = 1'b0;
    logic [7:0] rd_data;
    logic       loaded;
    logic       tick;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ftd_top dut_i (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .cmd_done_i(cmd_done), .rst_seq_i(rst_seq), .rd_data_o(rd_data),
        .loaded_o(loaded), .tick_o(tick)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] d, input logic done, input logic seq);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; cmd_done = done; rst_seq = seq;
        @(negedge clk);
        wr_en = 1'b0; cmd_done = 1'b1; rst_seq = 1'b0;
    endtask

    // Finds a strobe, then counts cycles to the next one.
    task automatic check_period(input string req, input int exp);
        int gap = 0;
        int seen = 0;
        for (int i = 0; i < 300 && !seen; i++) begin
            @(negedge clk);
            if (tick) seen = 1;
        end
        check(req, seen, 1);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            gap++;
            if (tick) break;
        end
        check(req, gap, exp);
    endtask

    task automatic t_reset();
        int ticks = 0;
        do_reset();
        check("R1", rd_data, 8'h00);
        check("R1", loaded, 0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (tick) ticks++;
        end
        check("R9", ticks, 0);
    endtask

    task automatic t_busy_unloaded();
        int ticks = 0;
        do_write(8'h45, 1'b0, 1'b0);
        check("R6", rd_data, 8'h00);
        check("R2", loaded, 0);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (tick) ticks++;
        end
        check("R9", ticks, 0);
    endtask

    task automatic t_seq_write();
        do_write(8'h03, 1'b0, 1'b1);
        check("R7", rd_data, 8'h83);
        check("R2", loaded, 1);
        check_period("R8", 4);
    endtask

    task automatic t_normal_and_busy();
        do_write(8'h09, 1'b1, 1'b0);
        check("R2", rd_data, 8'h89);
        check_period("R8", 10);
        do_write(8'h41, 1'b0, 1'b0);
        check("R6", rd_data, 8'h89);
        do_write(8'h00, 1'b1, 1'b0);
        check("R8", rd_data, 8'h80);
        check_period("R8", 1);
    endtask

    task automatic t_lock();
        do_write(8'h44, 1'b1, 1'b0);
        check("R5", rd_data, 8'hC4);
        check_period("R8", 5);
        do_write(8'h0A, 1'b1, 1'b0);
        check("R3", rd_data[6], 1);
        check("R4", rd_data, 8'hC4);
        do_write(8'h7F, 1'b0, 1'b1);
        check("R4", rd_data, 8'hC4);
        check_period("R4", 5);
        do_reset();
        check("R3", rd_data, 8'h00);
    endtask

    initial begin : wd
        repeat (WATCHDOG) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_busy_unloaded();
        t_seq_write();
        t_normal_and_busy();
        t_lock();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule